// File: doc/BRIEF.md
# Byte ALU with Masked Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor core. It is purely combinational. In one evaluation it takes an operation code, two byte operands, a 3-bit shift or bit index, and the processor's present 6-bit flag word. It returns the byte result, the next flag word and a write-back strobe. Instruction decoding and register-file access happen outside the block: the surrounding core picks the operands and stores `result` when `wr_en` is high.

Every operation builds a double-width intermediate value. The zero, carry, overflow and sign conditions all come from that intermediate. A per-operation mask then decides which flag bits take the new conditions. Every flag bit outside the mask, including the interrupt-enable and branch-skip bits, passes through unchanged.

Top module: `byte_alu`

## Requirements
- R1: Flag word layout is zero = bit 0, carry = bit 1, overflow = bit 2, sign = bit 3, interrupt-enable = bit 4, branch-skip = bit 5. Bits 4 and 5, and any flag bit that an operation does not update, leave the block equal to `flags_in`.
- R2: When updated, zero is 1 exactly when the low 8 bits of the 16-bit intermediate are all 0.
- R3: When updated, carry and overflow are both 1 exactly when bits 15:8 of the intermediate are nonzero, which is the same as the intermediate exceeding 0xFF.
- R4: When updated, sign equals bit 7 of the intermediate.
- R5: Op codes 0 (AND), 1 (OR) and 2 (XOR) combine `opa` with `opb` bitwise. The result is written back, and only zero and sign are updated.
- R6: Op code 4 (ADD) forms `opa + opb` and op code 6 (INC) forms `opa + 1`, both as 16-bit sums. The low byte is written back, and zero, carry, overflow and sign are updated.
- R7: Op code 5 (SUB) forms `opa - opb` and op code 7 (DEC) forms `opa - 1`, both in 16-bit two's complement, so a borrow sets carry and overflow. The low byte is written back, and zero, carry, overflow and sign are updated.
- R8: Op code 3 (CMP) updates zero, carry, overflow and sign exactly as SUB would, and drives `wr_en` low.
- R9: Op code 9 (SHL) shifts `opa` left by `sel` within the 16-bit intermediate, so bits shifted out set carry. Op code 10 (SHR) shifts `opa` right by `sel`. Both write back and update zero, carry and sign; overflow is kept.
- R10: Op code 11 (ROL) and op code 12 (ROR) rotate `opa` by `sel`, and a rotate by 0 returns `opa` unchanged. The intermediate's high byte is `opa >> (8-sel)` for ROL (0 when `sel` is 0) and `opa >> sel` for ROR. Both write back and update zero, carry and sign.
- R11: Op code 8 (BIT) sets zero when bit `sel` of `opa` is 0 and clears it otherwise. It changes no other flag and drives `wr_en` low.
- R12: Op codes 13 to 15 leave the whole flag word unchanged and drive `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand (register or immediate) |
| sel | input | 3 | Shift or rotate amount, or bit index for BIT |
| flags_in | input | 6 | Present flag word |
| result | output | 8 | Low byte of the intermediate |
| flags_out | output | 6 | Next flag word |
| wr_en | output | 1 | High when `result` must be written back |

## Verification
The assertions are immediate checks evaluated whenever an input changes. They take for granted only that every input holds a defined 0 or 1 value. Any such combination is legal, including the undefined op codes, so none is excluded. The stimulus therefore never has to avoid a region. It sweeps every op code against every `opa` value, a stride of `opb` values that includes both ends, and all eight `sel` values. It also varies `flags_in` so that the preserved bits take both polarities.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int FLAG_W = 6;
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FO = 2;
  localparam int FS = 3;
  localparam int FI = 4;
  localparam int FK = 5;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_CMP = 4'd3,
    OP_ADD = 4'd4,
    OP_SUB = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_BIT = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10,
    OP_ROL = 4'd11,
    OP_ROR = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic              wr;
    logic [FLAG_W-1:0] mask;
  } op_ctl_t;

  localparam logic [FLAG_W-1:0] M_ZS   = 6'b001001;
  localparam logic [FLAG_W-1:0] M_ZCOS = 6'b001111;
  localparam logic [FLAG_W-1:0] M_ZCS  = 6'b001011;
  localparam logic [FLAG_W-1:0] M_Z    = 6'b000001;

  function automatic op_ctl_t ctl_of(input logic [3:0] op);
    op_ctl_t c;
    c = '{wr: 1'b0, mask: '0};
    case (op)
      OP_AND, OP_OR, OP_XOR:          c = '{wr: 1'b1, mask: M_ZS};
      OP_ADD, OP_SUB, OP_INC, OP_DEC: c = '{wr: 1'b1, mask: M_ZCOS};
      OP_CMP:                         c = '{wr: 1'b0, mask: M_ZCOS};
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: c = '{wr: 1'b1, mask: M_ZCS};
      OP_BIT:                         c = '{wr: 1'b0, mask: M_Z};
      default:                        c = '{wr: 1'b0, mask: '0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [3:0]     op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SW-1:0]  n,
  output logic [2*W-1:0] inter
);
  import byte_alu_pkg::*;

  localparam int DW = 2 * W;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [DW-1:0] widen(input logic [W-1:0] x);
    return {{W{1'b0}}, x};
  endfunction

  function automatic logic [DW-1:0] f_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return widen(x) + widen(y);
  endfunction

  function automatic logic [DW-1:0] f_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return widen(x) - widen(y);
  endfunction

  function automatic logic [DW-1:0] f_shl(input logic [W-1:0] x, input logic [SW-1:0] k);
    return widen(x) << k;
  endfunction

  function automatic logic [DW-1:0] f_shr(input logic [W-1:0] x, input logic [SW-1:0] k);
    return widen(x) >> k;
  endfunction

  function automatic logic [DW-1:0] f_rol(input logic [W-1:0] x, input logic [SW-1:0] k);
    logic [DW-1:0] back;
    back = (k == '0) ? '0 : (widen(x) >> (W - int'(k)));
    return (widen(x) << k) | back;
  endfunction

  function automatic logic [DW-1:0] f_ror(input logic [W-1:0] x, input logic [SW-1:0] k);
    return (widen(x) >> k) | (widen(x) << (W - int'(k)));
  endfunction

  function automatic logic [DW-1:0] f_bit(input logic [W-1:0] x, input logic [SW-1:0] k);
    return widen(x & (ONE << k));
  endfunction

  always_comb begin
    case (op)
      OP_AND:         inter = widen(a & b);
      OP_OR:          inter = widen(a | b);
      OP_XOR:         inter = widen(a ^ b);
      OP_ADD:         inter = f_add(a, b);
      OP_INC:         inter = f_add(a, ONE);
      OP_SUB, OP_CMP: inter = f_sub(a, b);
      OP_DEC:         inter = f_sub(a, ONE);
      OP_BIT:         inter = f_bit(a, n);
      OP_SHL:         inter = f_shl(a, n);
      OP_SHR:         inter = f_shr(a, n);
      OP_ROL:         inter = f_rol(a, n);
      OP_ROR:         inter = f_ror(a, n);
      default:        inter = '0;
    endcase
  end

endmodule

// File: rtl/flag_merge.sv
module flag_merge #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] inter,
  input  logic [5:0]     mask,
  input  logic [5:0]     flags_in,
  output logic [5:0]     flags_out,
  output logic           hi_nz,
  output logic           lo_zero
);
  import byte_alu_pkg::*;

  localparam logic [2*W-1:0] LIMIT = {{W{1'b0}}, {W{1'b1}}};

  logic [5:0] raw;

  assign hi_nz   = |inter[2*W-1:W];
  assign lo_zero = (inter[W-1:0] == '0);

  always_comb begin
    raw     = '0;
    raw[FZ] = lo_zero;
    raw[FC] = hi_nz;
    raw[FO] = (inter > LIMIT);
    raw[FS] = inter[W-1];
  end

  assign flags_out = (raw & mask) | (flags_in & ~mask);

endmodule

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SEL_W-1:0]  sel,
  input  logic [5:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic [5:0]        flags_out,
  output logic              wr_en
);
  import byte_alu_pkg::*;

  logic [2*DATA_W-1:0] inter;
  op_ctl_t             ctl;
  logic                hi_nz;
  logic                lo_zero;

  assign ctl = ctl_of(op);

  alu_core #(.W(DATA_W), .SW(SEL_W)) u_core (
    .op    (op),
    .a     (opa),
    .b     (opb),
    .n     (sel),
    .inter (inter)
  );

  flag_merge #(.W(DATA_W)) u_flags (
    .inter     (inter),
    .mask      (ctl.mask),
    .flags_in  (flags_in),
    .flags_out (flags_out),
    .hi_nz     (hi_nz),
    .lo_zero   (lo_zero)
  );

  assign result = inter[DATA_W-1:0];
  assign wr_en  = ctl.wr;

  always_comb begin
    // R1
    sys_bits_kept_chk: assert (flags_out[FK:FI] == flags_in[FK:FI]);
    // R2
    zero_from_result_chk: assert (!ctl.mask[FZ] || (flags_out[FZ] == (result == '0)));
    // R3
    carry_ovf_pair_chk: assert (!(ctl.mask[FC] && ctl.mask[FO]) || (flags_out[FC] == flags_out[FO]));
    // R8
    cmp_no_write_chk: assert (op != OP_CMP || !wr_en);
    // R11
    bit_only_zero_chk: assert (op != OP_BIT || (flags_out[5:1] == flags_in[5:1] && !wr_en));
    // R12
    undef_idle_chk: assert (op < 4'd13 || (flags_out == flags_in && !wr_en));
  end

endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic [2:0] sel = '0;
  logic [5:0] flags_in = '0;
  logic [7:0] result;
  logic [5:0] flags_out;
  logic       wr_en;

  int nvec = 0;
  int nbad = 0;
  int cycles = 0;

  byte_alu u0 (
    .op(op), .opa(opa), .opb(opb), .sel(sel), .flags_in(flags_in),
    .result(result), .flags_out(flags_out), .wr_en(wr_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      nbad = nbad + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic apply(input int o, input int a, input int b, input int n,
                       input int fin, input string tag);
    int v, lo, hn, mask, wr, raw, ef;
    op = 4'(o); opa = 8'(a); opb = 8'(b); sel = 3'(n); flags_in = 6'(fin);
    #1;
    wr = 1; mask = 0; v = 0;
    case (o)
      0: begin v = a & b; mask = 'h9; end
      1: begin v = a | b; mask = 'h9; end
      2: begin v = a ^ b; mask = 'h9; end
      3: begin v = (a - b) & 'hFFFF; mask = 'hF; wr = 0; end
      4: begin v = a + b; mask = 'hF; end
      5: begin v = (a - b) & 'hFFFF; mask = 'hF; end
      6: begin v = a + 1; mask = 'hF; end
      7: begin v = (a - 1) & 'hFFFF; mask = 'hF; end
      8: begin v = ((a >> n) & 1) != 0 ? 1 : 0; mask = 'h1; wr = 0; end
      9: begin v = (a << n) & 'hFFFF; mask = 'hB; end
      10: begin v = a >> n; mask = 'hB; end
      11: begin
        lo = 0;
        for (int i = 0; i < 8; i++)
          if (((a >> ((i - n + 8) % 8)) & 1) != 0) lo = lo | (1 << i);
        v = lo | (((n == 0) ? 0 : (a >> (8 - n))) << 8);
        mask = 'hB;
      end
      12: begin
        lo = 0;
        for (int i = 0; i < 8; i++)
          if (((a >> ((i + n) % 8)) & 1) != 0) lo = lo | (1 << i);
        v = lo | ((a >> n) << 8);
        mask = 'hB;
      end
      default: begin v = 0; mask = 0; wr = 0; end
    endcase
    lo = v & 'hFF;
    hn = ((v >> 8) != 0) ? 1 : 0;
    raw = ((lo == 0) ? 1 : 0) | (hn << 1) | (hn << 2) | (((lo >> 7) & 1) << 3);
    ef = ((raw & mask) | (fin & ~mask)) & 'h3F;
    nvec = nvec + 1;
    if (wr_en !== 1'(wr) || flags_out !== 6'(ef) || (wr == 1 && result !== 8'(lo))) begin
      nbad = nbad + 1;
      $display("FAIL %s op=%0d a=%02h b=%02h n=%0d fin=%02h: got r=%02h f=%02h w=%0b exp r=%02h f=%02h w=%0d",
               tag, o, a, b, n, fin, result, flags_out, wr_en, lo, ef, wr);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0, 1, 2: return "R5";
      3: return "R8";
      4, 6: return "R6";
      5, 7: return "R7";
      8: return "R11";
      9, 10: return "R9";
      11, 12: return "R10";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset-time state: AND of zeros gives zero flag, write-back
    apply(0, 0, 0, 0, 0, "R5");
    // R1: preserved system bits and untouched flags
    apply(4, 'h10, 'h20, 0, 'h3F, "R1");
    apply(0, 'hFF, 'h0F, 0, 'h36, "R1");
    // R2: low byte zero with a carry out
    apply(4, 'h80, 'h80, 0, 0, "R2");
    // R3: borrow sets carry and overflow together
    apply(5, 'h00, 'h01, 0, 0, "R3");
    apply(7, 'h00, 'h00, 0, 0, "R3");
    // R4: sign copies bit 7
    apply(1, 'h80, 'h00, 0, 0, "R4");
    // R10: rotate by zero keeps the operand
    apply(11, 'hA5, 0, 0, 0, "R10");
    apply(12, 'hA5, 0, 0, 0, "R10");
    // R9: maximum shift amount
    apply(9, 'hFF, 0, 7, 0, "R9");
    // R11: bit test on set and clear bits
    apply(8, 'h80, 0, 7, 'h3E, "R11");
    apply(8, 'h7F, 0, 7, 'h00, "R11");
    for (int o = 0; o < 13; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 5)
          apply(o, a, b, (a + b + o) % 8, (a * 7 + b * 3 + o) & 'h3F, tag_of(o));
    for (int o = 13; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 51)
          apply(o, a, b, (a + b) % 8, (a ^ b) & 'h3F, "R12");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule